// File: doc/BRIEF.md
# Stepped Digital AGC Controller

This block sits behind a digital down-converter and keeps the IF level of a radio front end steady. It takes a stream of baseband I/Q samples and measures the envelope of each sample as |I| + |Q|. It averages that envelope over a fixed frame of 2^FRAME_LOG2 accepted samples. It turns the average into a logarithmic level in steps of about half a decibel. It then places that level in one of five power bands.

Each band maps to a fixed gain step. The steps are asymmetric: a strong signal pulls the gain down hard, and a weak signal raises it in small steps. The new gain is clamped to 0..GAIN_MAX. At the end of every frame the block publishes the gain with a one-cycle strobe, which a serial link controller uses to program the front end. The measured level of the latest frame is also visible on a port.

Top module: `agc_stepper`

## Requirements
- R1: While rst is high and on the first cycle after it, gain equals GAIN_INIT (25), gain_valid is low and frame_level is 0.
- R2: The envelope of a sample is |I| + |Q| using two's-complement magnitudes, so the most negative input value counts as its full magnitude (-32768 gives 32768), and the envelope is SAMPLE_W+1 bits wide.
- R3: A frame is 2^FRAME_LOG2 samples accepted with in_valid high. Cycles with in_valid low are skipped. The frame average is floor(sum of envelopes / 2^FRAME_LOG2).
- R4: frame_level for an average A is 0 when A = 0. Otherwise it is 12*p + T[m], where p is the index of the leading one of A, m is the 4 bits directly below that leading one (zero-filled when p < 4), and T[m] = round(12.0412*log2(1 + m/16)), which gives 0,1,2,3,4,5,6,6,7,8,8,9,10,10,11,11 for m = 0..15.
- R5: The gain step depends on frame_level: -5 when frame_level >= 156; -1 when frame_level is 132..155; 0 when it is 108..131; +1 when it is 84..107; +3 when it is below 84.
- R6: The stepped gain is clamped: a result below 0 becomes 0 and a result above GAIN_MAX (50) becomes GAIN_MAX.
- R7: Each frame produces exactly one gain_valid pulse, one cycle long, in the 4th cycle after the clock edge that accepts the frame's last sample. frame_level takes the frame's value one cycle before that pulse.
- R8: gain changes only in a cycle where gain_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample qualifier |
| in_i | input | SAMPLE_W | In-phase sample, signed |
| in_q | input | SAMPLE_W | Quadrature sample, signed |
| gain | output | GAIN_W | Current front-end gain value |
| gain_valid | output | 1 | One-cycle strobe when a new gain is issued |
| frame_level | output | 8 | Log level of the last frame, about 0.5 dB per unit |

## Verification
The assertions check, on every cycle, that the gain stays within range and moves only with the strobe, and that the strobe is a single cycle that follows a change in level. They also check the direction of each move for the strongest, the weakest and the hold band. The exact numbers can only be shown by the bench's scenarios: the envelope of extreme negative inputs, the truncating frame average across idle gaps, the leading-one and fraction log mapping, the exact step per band, the pile-up against both clamps and the cycle latency. The bench sweeps every leading-one position and every fraction value against an arithmetic model of R2 to R7.

// File: rtl/agc_pkg.sv
package agc_pkg;

    localparam int LVL_W = 8;

    typedef logic [LVL_W-1:0] level_t;

    typedef enum logic [2:0] {
        BAND_COLD,
        BAND_COOL,
        BAND_HOLD,
        BAND_WARM,
        BAND_HOT
    } band_e;

    typedef struct packed {
        logic   valid;
        level_t level;
    } level_msg_t;

    // fractional part of the log: round(12.0412 * log2(1 + m/16))
    function automatic logic [3:0] frac_lut(input logic [3:0] m);
        logic [3:0] r;
        case (m)
            4'd0:  r = 4'd0;
            4'd1:  r = 4'd1;
            4'd2:  r = 4'd2;
            4'd3:  r = 4'd3;
            4'd4:  r = 4'd4;
            4'd5:  r = 4'd5;
            4'd6:  r = 4'd6;
            4'd7:  r = 4'd6;
            4'd8:  r = 4'd7;
            4'd9:  r = 4'd8;
            4'd10: r = 4'd8;
            4'd11: r = 4'd9;
            4'd12: r = 4'd10;
            4'd13: r = 4'd10;
            4'd14: r = 4'd11;
            default: r = 4'd11;
        endcase
        return r;
    endfunction

    function automatic logic signed [3:0] step_of(input band_e b);
        logic signed [3:0] s;
        case (b)
            BAND_HOT:  s = -4'sd5;
            BAND_WARM: s = -4'sd1;
            BAND_HOLD: s = 4'sd0;
            BAND_COOL: s = 4'sd1;
            default:   s = 4'sd3;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/agc_envelope.sv
module agc_envelope #(
    parameter int SAMPLE_W = 16,
    localparam int ENV_W   = SAMPLE_W + 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_i,
    input  logic [SAMPLE_W-1:0] in_q,
    output logic                env_valid,
    output logic [ENV_W-1:0]    env
);

    logic [SAMPLE_W-1:0] raw [2];
    logic [SAMPLE_W-1:0] mag [2];

    assign raw[0] = in_i;
    assign raw[1] = in_q;

    // one magnitude unit per rail; the most negative code maps to 2^(W-1)
    for (genvar c = 0; c < 2; c++) begin : g_mag
        assign mag[c] = raw[c][SAMPLE_W-1] ? (~raw[c] + 1'b1) : raw[c];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            env_valid <= 1'b0;
            env       <= '0;
        end else begin
            env_valid <= in_valid;
            if (in_valid) begin
                env <= {1'b0, mag[0]} + {1'b0, mag[1]};
            end
        end
    end

endmodule

// File: rtl/agc_frame_acc.sv
module agc_frame_acc #(
    parameter int ENV_W      = 17,
    parameter int FRAME_LOG2 = 10,
    localparam int ACC_W     = ENV_W + FRAME_LOG2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             env_valid,
    input  logic [ENV_W-1:0] env,
    output logic             avg_valid,
    output logic [ENV_W-1:0] avg
);

    logic [FRAME_LOG2-1:0] cnt;
    logic [ACC_W-1:0]      acc;
    logic [ACC_W-1:0]      sum;
    logic                  last;

    assign sum  = acc + ACC_W'(env);
    assign last = &cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            acc       <= '0;
            avg       <= '0;
            avg_valid <= 1'b0;
        end else begin
            avg_valid <= 1'b0;
            if (env_valid) begin
                cnt <= cnt + 1'b1;
                if (last) begin
                    acc       <= '0;
                    avg       <= sum[ACC_W-1:FRAME_LOG2];
                    avg_valid <= 1'b1;
                end else begin
                    acc <= sum;
                end
            end
        end
    end

endmodule

// File: rtl/agc_log_conv.sv
module agc_log_conv
    import agc_pkg::*;
#(
    parameter int AVG_W  = 17,
    localparam int POS_W = $clog2(AVG_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             avg_valid,
    input  logic [AVG_W-1:0] avg,
    output level_msg_t       out
);

    logic [POS_W-1:0] lead;
    logic [AVG_W-1:0] norm;
    logic [3:0]       frac;
    level_t           lvl_d;

    // highest set bit wins
    always_comb begin
        lead = '0;
        for (int b = 0; b < AVG_W; b++) begin
            if (avg[b]) lead = POS_W'(b);
        end
    end

    assign norm = avg << (POS_W'(AVG_W - 1) - lead);
    assign frac = norm[AVG_W-2 -: 4];

    always_comb begin
        if (avg == '0) lvl_d = '0;
        else           lvl_d = LVL_W'(int'(lead) * 12 + int'(frac_lut(frac)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out <= '0;
        end else begin
            out.valid <= avg_valid;
            if (avg_valid) out.level <= lvl_d;
        end
    end

endmodule

// File: rtl/agc_gain_step.sv
module agc_gain_step
    import agc_pkg::*;
#(
    parameter int GAIN_W    = 6,
    parameter int GAIN_MAX  = 50,
    parameter int GAIN_INIT = 25,
    parameter int TH_LOW    = 84,
    parameter int TH_MID    = 108,
    parameter int TH_HIGH   = 132,
    parameter int TH_TOP    = 156
) (
    input  logic              clk,
    input  logic              rst,
    input  level_msg_t        in,
    output logic [GAIN_W-1:0] gain,
    output logic              gain_valid
);

    localparam int SUM_W = GAIN_W + 2;
    localparam level_t L_LOW  = level_t'(TH_LOW);
    localparam level_t L_MID  = level_t'(TH_MID);
    localparam level_t L_HIGH = level_t'(TH_HIGH);
    localparam level_t L_TOP  = level_t'(TH_TOP);
    localparam logic signed [SUM_W-1:0] MAX_S = SUM_W'(GAIN_MAX);

    band_e                    band;
    logic signed [SUM_W-1:0]  stepped;
    logic [GAIN_W-1:0]        clamped;

    always_comb begin
        if (in.level >= L_TOP)       band = BAND_HOT;
        else if (in.level >= L_HIGH) band = BAND_WARM;
        else if (in.level >= L_MID)  band = BAND_HOLD;
        else if (in.level >= L_LOW)  band = BAND_COOL;
        else                         band = BAND_COLD;
    end

    assign stepped = $signed({2'b00, gain}) + SUM_W'(step_of(band));

    always_comb begin
        if (stepped < 0)          clamped = '0;
        else if (stepped > MAX_S) clamped = GAIN_W'(GAIN_MAX);
        else                      clamped = stepped[GAIN_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gain       <= GAIN_W'(GAIN_INIT);
            gain_valid <= 1'b0;
        end else begin
            gain_valid <= in.valid;
            if (in.valid) gain <= clamped;
        end
    end

endmodule

// File: rtl/agc_stepper.sv
module agc_stepper
    import agc_pkg::*;
#(
    parameter int SAMPLE_W   = 16,
    parameter int FRAME_LOG2 = 10,
    parameter int GAIN_W     = 6,
    parameter int GAIN_MAX   = 50,
    parameter int GAIN_INIT  = 25,
    parameter int TH_LOW     = 84,
    parameter int TH_MID     = 108,
    parameter int TH_HIGH    = 132,
    parameter int TH_TOP     = 156
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [SAMPLE_W-1:0] in_i,
    input  logic [SAMPLE_W-1:0] in_q,
    output logic [GAIN_W-1:0]   gain,
    output logic                gain_valid,
    output logic [LVL_W-1:0]    frame_level
);

    localparam int ENV_W = SAMPLE_W + 1;

    logic             env_valid;
    logic [ENV_W-1:0] env;
    logic             avg_valid;
    logic [ENV_W-1:0] avg;
    level_msg_t       lvl;

    agc_envelope #(.SAMPLE_W(SAMPLE_W)) u_env (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_i      (in_i),
        .in_q      (in_q),
        .env_valid (env_valid),
        .env       (env)
    );

    agc_frame_acc #(.ENV_W(ENV_W), .FRAME_LOG2(FRAME_LOG2)) u_acc (
        .clk       (clk),
        .rst       (rst),
        .env_valid (env_valid),
        .env       (env),
        .avg_valid (avg_valid),
        .avg       (avg)
    );

    agc_log_conv #(.AVG_W(ENV_W)) u_log (
        .clk       (clk),
        .rst       (rst),
        .avg_valid (avg_valid),
        .avg       (avg),
        .out       (lvl)
    );

    agc_gain_step #(
        .GAIN_W    (GAIN_W),
        .GAIN_MAX  (GAIN_MAX),
        .GAIN_INIT (GAIN_INIT),
        .TH_LOW    (TH_LOW),
        .TH_MID    (TH_MID),
        .TH_HIGH   (TH_HIGH),
        .TH_TOP    (TH_TOP)
    ) u_gain (
        .clk        (clk),
        .rst        (rst),
        .in         (lvl),
        .gain       (gain),
        .gain_valid (gain_valid)
    );

    assign frame_level = lvl.level;

endmodule

// File: rtl/agc_stepper_chk.sv
module agc_stepper_chk #(
    parameter int GAIN_W   = 6,
    parameter int GAIN_MAX = 50,
    parameter int TH_LOW   = 84,
    parameter int TH_MID   = 108,
    parameter int TH_HIGH  = 132,
    parameter int TH_TOP   = 156
) (
    input logic              clk,
    input logic              rst,
    input logic [GAIN_W-1:0] gain,
    input logic              gain_valid,
    input logic [7:0]        frame_level
);

    localparam logic [GAIN_W-1:0] G_MAX = GAIN_W'(GAIN_MAX);
    localparam logic [7:0] L_LOW  = 8'(TH_LOW);
    localparam logic [7:0] L_MID  = 8'(TH_MID);
    localparam logic [7:0] L_HIGH = 8'(TH_HIGH);
    localparam logic [7:0] L_TOP  = 8'(TH_TOP);

    // R6
    gain_range_chk: assert property (@(posedge clk) disable iff (rst)
        gain <= G_MAX);

    // R7
    strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
        gain_valid |=> !gain_valid);

    // R7
    level_then_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_level != $past(frame_level)) |=> gain_valid);

    // R8
    gain_moves_on_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (gain != $past(gain)) |-> gain_valid);

    // R5
    hot_drops_chk: assert property (@(posedge clk) disable iff (rst)
        (gain_valid && frame_level >= L_TOP) |-> (gain < $past(gain) || gain == '0));

    // R5
    cold_rises_chk: assert property (@(posedge clk) disable iff (rst)
        (gain_valid && frame_level < L_LOW) |-> (gain > $past(gain) || gain == G_MAX));

    // R5
    hold_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (gain_valid && frame_level >= L_MID && frame_level < L_HIGH) |-> gain == $past(gain));

endmodule

bind agc_stepper agc_stepper_chk #(
    .GAIN_W   (GAIN_W),
    .GAIN_MAX (GAIN_MAX),
    .TH_LOW   (TH_LOW),
    .TH_MID   (TH_MID),
    .TH_HIGH  (TH_HIGH),
    .TH_TOP   (TH_TOP)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .gain        (gain),
    .gain_valid  (gain_valid),
    .frame_level (frame_level)
);

// File: tb/tb_agc_stepper.sv
module tb_agc_stepper;

    localparam int CLK_PERIOD = 10;
    localparam int SW   = 16;
    localparam int FL2  = 2;
    localparam int NS   = 1 << FL2;
    localparam int GMAX = 50;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [SW-1:0] in_i = '0;
    logic [SW-1:0] in_q = '0;
    logic [5:0]    gain;
    logic          gain_valid;
    logic [7:0]    frame_level;

    int checks = 0;
    int failures = 0;
    int pulses = 0;
    int exp_gain = 25;
    int tbl [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    agc_stepper #(.SAMPLE_W(SW), .FRAME_LOG2(FL2)) dut (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_i        (in_i),
        .in_q        (in_q),
        .gain        (gain),
        .gain_valid  (gain_valid),
        .frame_level (frame_level)
    );

    always @(negedge clk) if (gain_valid) pulses++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_level(input int a);
        int p;
        int m;
        if (a == 0) return 0;
        p = 0;
        for (int b = 0; b < 20; b++) if ((a >> b) & 1) p = b;
        m = (p >= 4) ? ((a >> (p - 4)) & 15) : ((a << (4 - p)) & 15);
        return 12 * p + tbl[m];
    endfunction

    function automatic int model_step(input int lvl);
        if (lvl >= 156) return -5;
        if (lvl >= 132) return -1;
        if (lvl >= 108) return 0;
        if (lvl >= 84)  return 1;
        return 3;
    endfunction

    function automatic logic [SW-1:0] to_sample(input int mag, input bit neg);
        if (neg || mag == 32768) return SW'(-mag);
        return SW'(mag);
    endfunction

    // sends one frame of envelopes e[0..3]; gap idle cycles between samples
    task automatic run_frame(input int e0, input int e1, input int e2, input int e3,
                             input int gap, input string tag);
        int e [NS];
        int sum;
        int lvl;
        int wait_n;
        int p0;
        e[0] = e0; e[1] = e1; e[2] = e2; e[3] = e3;
        sum = 0;
        @(posedge clk); #1;
        // R8: gain stays put between strobes
        check(gain == exp_gain, {"R8 ", tag}, gain, exp_gain);
        p0 = pulses;
        for (int k = 0; k < NS; k++) begin
            int a;
            a = e[k] / 2;
            in_i = to_sample(a, k[0]);
            in_q = to_sample(e[k] - a, k[1]);
            in_valid = 1'b1;
            sum += e[k];
            @(posedge clk); #1;
            in_valid = 1'b0;
            if (k != NS - 1) begin
                for (int g = 0; g < gap; g++) begin
                    @(posedge clk); #1;
                end
            end
        end
        wait_n = 0;
        for (int n = 1; n <= 10; n++) begin
            @(negedge clk);
            if (gain_valid) begin
                wait_n = n;
                break;
            end
        end
        // R7 latency
        check(wait_n == 4, {"R7 latency ", tag}, wait_n, 4);
        lvl = model_level(sum / NS);
        // R3 / R4 level of the frame average
        check(frame_level == lvl, {"R3 R4 level ", tag}, frame_level, lvl);
        exp_gain = exp_gain + model_step(lvl);
        if (exp_gain < 0) exp_gain = 0;
        if (exp_gain > GMAX) exp_gain = GMAX;
        // R5 / R6 issued gain
        check(gain == exp_gain, {"R5 R6 gain ", tag}, gain, exp_gain);
        @(negedge clk);
        // R7 one pulse per frame
        check(!gain_valid && pulses == p0 + 1, {"R7 single pulse ", tag}, pulses - p0, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int m = 0; m < 16; m++)
            tbl[m] = $rtoi(12.0412 * $ln(1.0 + m / 16.0) / $ln(2.0) + 0.5);

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 during reset
        check(gain == 25 && !gain_valid && frame_level == 0, "R1 in reset", gain, 25);
        @(posedge clk); #1;
        rst = 1'b0;
        @(negedge clk);
        // R1 first cycle after reset
        check(gain == 25 && !gain_valid && frame_level == 0, "R1 after reset", gain, 25);

        // R2: full negative inputs give envelope 65536
        run_frame(65536, 65536, 65536, 65536, 0, "R2 extreme");
        check(frame_level == 192, "R2 level of 65536", frame_level, 192);

        // R3: truncating average, idle gaps skipped
        run_frame(1, 2, 3, 5, 2, "R3 gaps");
        run_frame(100, 300, 701, 0, 1, "R3 mixed");

        // R4/R5: sweep every leading-one position and fraction
        for (int ex = 0; ex <= 16; ex++) begin
            for (int m = 0; m < 16; m++) begin
                int a;
                a = (ex >= 4) ? ((16 + m) << ex) >> 4 : (16 + m) >> (4 - ex);
                if (a <= 65536) run_frame(a, a, a, a, 0, "R4 sweep");
            end
        end
        run_frame(0, 0, 0, 0, 0, "R4 zero");

        // R6: drive to the lower clamp, then the upper clamp
        for (int k = 0; k < 12; k++) run_frame(65535, 65535, 65535, 65535, 0, "R6 low clamp");
        check(gain == 0, "R6 floor", gain, 0);
        for (int k = 0; k < 20; k++) run_frame(1, 1, 1, 1, 0, "R6 high clamp");
        check(gain == GMAX, "R6 ceiling", gain, GMAX);

        // R5: band edges
        run_frame(8192, 8192, 8192, 8192, 0, "R5 edge 156");
        run_frame(4095, 4095, 4095, 4095, 0, "R5 below 156");
        run_frame(2048, 2048, 2048, 2048, 0, "R5 edge 132");
        run_frame(512, 512, 512, 512, 0, "R5 edge 108");
        run_frame(128, 128, 128, 128, 0, "R5 edge 84");
        run_frame(127, 127, 127, 127, 0, "R5 below 84");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule